// File: doc/BRIEF.md
# Slot Interrupt Screening and Dispatch Controller

This block takes interrupt requests from thirty I/O slots and screens each one against two enable masks. A slot that is not enabled raises a sticky major fault. A slot that is enabled but whose interrupt is masked gets its pending bit set. A slot with both enables set can start a service routine. When several slots qualify in the same cycle, the lowest-numbered slot starts first. Only one slot routine runs at a time. While a slot routine, a timed interrupt or a fault routine is running, no request is evaluated. Requests are level-sensitive, so a request that is still held is looked at again once the block is free.

Software sees three register pairs through a 16-bit word port. The enable pairs can be written, but a write only lands in a shadow copy, and the shadow is copied into the live mask on the end-of-scan strobe. The pending pair can only be read. A separate command clears the pending bit of one named slot. When a routine is dispatched, the block saves four context words: flags, the low and high math words, and the index. It hands them back on the routine-done strobe so the caller can write them back.

Top module: `slot_irq_ctrl`

## Requirements
- R1: Slot n (1..30) sits at bit n of a 32-bit vector. The low word is bits 15..0 and the high word is bits 31..16. Register address bits [2:1] select the group: 0 is slot enable, 1 is interrupt enable, 2 is pending, and 3 reads zero. Address bit 0 selects the high word. Bit 0 of each low word and bit 15 of each high word always read zero. Writes to the pending group have no effect.
- R2: A write to the slot-enable or interrupt-enable group changes only a shadow copy, and reads return the live mask. On end_of_scan the live masks load the shadow, including any write made in that same cycle.
- R3: A request from a slot whose live slot-enable bit is clear sets major_fault after the next edge. major_fault stays set until reset.
- R4: A request from a slot whose slot enable is set but whose live interrupt enable is clear sets that slot's pending bit after the next edge.
- R5: A pending bit is cleared on the edge after its live interrupt-enable bit reads one.
- R6: When clr_pend_valid is high and clr_pend_slot is in 1..30, that slot's pending bit is cleared on the next edge, and the clear wins over a set in the same cycle. Slot 0 and slots 31 and above have no effect.
- R7: When no routine is blocking and at least one slot has both enables set and is requesting, dispatch pulses for one cycle after the next edge. dispatch_slot carries the lowest such slot, and isr_active rises.
- R8: While isr_active or hp_busy is high, requests cause no dispatch, no pending set and no fault.
- R9: The four context words present at dispatch are saved. isr_done while isr_active clears isr_active, and on the next edge restore_valid pulses for one cycle with the saved words.
- R10: A request held across a blocking period is evaluated in the first cycle after the blocking ends.
- R11: After reset all masks, pending bits, major_fault, dispatch, isr_active and restore_valid are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| slot_req | input | 30 | Level request per slot, bit n is slot n |
| end_of_scan | input | 1 | Copy shadow enables into live masks |
| clr_pend_valid | input | 1 | Clear-pending command strobe |
| clr_pend_slot | input | 5 | Slot named by the clear-pending command |
| hp_busy | input | 1 | Timed interrupt or fault routine running |
| isr_done | input | 1 | Slot routine finished |
| ctx_flags_in | input | 16 | Current arithmetic flags word |
| ctx_math_lo_in | input | 16 | Current math register low word |
| ctx_math_hi_in | input | 16 | Current math register high word |
| ctx_index_in | input | 16 | Current index register word |
| dispatch | output | 1 | One-cycle routine start pulse |
| dispatch_slot | output | 5 | Slot being started |
| isr_active | output | 1 | A slot routine is in service |
| major_fault | output | 1 | Sticky fault for a request from a disabled slot |
| restore_valid | output | 1 | One-cycle pulse with the saved context |
| restore_flags | output | 16 | Saved flags word |
| restore_math_lo | output | 16 | Saved math low word |
| restore_math_hi | output | 16 | Saved math high word |
| restore_index | output | 16 | Saved index word |

## Verification
The hardest situation to reach from the ports is a set of overlapping events in a single cycle. Examples are a request landing while a routine is still active, a clear-pending command meeting a fresh pending set, and an end-of-scan copy racing a masking write. Directed sequences hold a request through an active routine and through hp_busy, then release the block to show the request being evaluated on the next cycle. A seeded random phase then drives sparse multi-slot requests together with random busy, done, clear-pending and mask writes. It compares every output and a register read each cycle against a cycle model kept in the bench.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;
  parameter int unsigned WORD_W    = 16;
  parameter int unsigned NUM_SLOTS = 30;
  localparam int unsigned FLAT_W   = 2 * WORD_W;
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS + 1);
  localparam int unsigned ADDR_W   = 3;

  typedef logic [FLAT_W-1:0] flat_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    word_t flags;
    word_t math_lo;
    word_t math_hi;
    word_t index;
  } ctx_t;

  localparam logic [1:0] GRP_SEN  = 2'd0;
  localparam logic [1:0] GRP_IEN  = 2'd1;
  localparam logic [1:0] GRP_PEND = 2'd2;

  // bits that map to a real slot
  function automatic flat_t live_mask();
    flat_t m;
    m = '0;
    for (int i = 1; i <= int'(NUM_SLOTS); i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic flat_t req_to_flat(logic [NUM_SLOTS:1] r);
    flat_t f;
    f = '0;
    f[NUM_SLOTS:1] = r;
    return f;
  endfunction

  function automatic word_t word_of(flat_t f, logic hi);
    return hi ? f[FLAT_W-1:WORD_W] : f[WORD_W-1:0];
  endfunction

  function automatic flat_t with_word(flat_t f, logic hi, word_t w);
    flat_t r;
    r = f;
    if (hi) r[FLAT_W-1:WORD_W] = w;
    else    r[WORD_W-1:0]      = w;
    return r & live_mask();
  endfunction

  // lowest set slot bit, zero when none
  function automatic slot_t lowest_slot(flat_t v);
    slot_t s;
    s = '0;
    for (int i = int'(FLAT_W) - 1; i >= 1; i--) if (v[i]) s = slot_t'(i);
    return s;
  endfunction

  // one-hot of a slot number, zero when outside 1..NUM_SLOTS
  function automatic flat_t slot_bit(slot_t s);
    flat_t r;
    r = '0;
    if (s != '0 && int'(s) <= int'(NUM_SLOTS)) r[s] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/slot_irq_regs.sv
module slot_irq_regs
  import slot_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  word_t             wdata,
  input  logic              eos,
  input  flat_t             pend,
  output word_t             rdata,
  output flat_t             sen_act,
  output flat_t             ien_act
);
  flat_t sen_sh, ien_sh, sen_sh_nx, ien_sh_nx;
  logic [1:0] grp;
  logic       hi;

  assign grp = addr[2:1];
  assign hi  = addr[0];

  always_comb begin
    sen_sh_nx = sen_sh;
    ien_sh_nx = ien_sh;
    if (wr && grp == GRP_SEN) sen_sh_nx = with_word(sen_sh, hi, wdata);
    if (wr && grp == GRP_IEN) ien_sh_nx = with_word(ien_sh, hi, wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sen_sh  <= '0;
      ien_sh  <= '0;
      sen_act <= '0;
      ien_act <= '0;
    end else begin
      sen_sh <= sen_sh_nx;
      ien_sh <= ien_sh_nx;
      if (eos) begin
        sen_act <= sen_sh_nx;
        ien_act <= ien_sh_nx;
      end
    end
  end

  always_comb begin
    unique case (grp)
      GRP_SEN:  rdata = word_of(sen_act, hi);
      GRP_IEN:  rdata = word_of(ien_act, hi);
      GRP_PEND: rdata = word_of(pend, hi);
      default:  rdata = '0;
    endcase
  end

  AST_MASKS_HOLD_OFF_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    !eos |=> ($stable(sen_act) && $stable(ien_act))); // R2
  AST_RESERVED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hi ? !rdata[WORD_W-1] : !rdata[0])); // R1
endmodule

// File: rtl/slot_irq_screen.sv
module slot_irq_screen
  import slot_irq_pkg::*;
(
  input  flat_t req,
  input  flat_t sen,
  input  flat_t ien,
  input  logic  blocked,
  output logic  fault_hit,
  output flat_t pend_set,
  output flat_t elig,
  output logic  disp_fire,
  output slot_t disp_slot
);
  flat_t bad;
  flat_t live;

  assign live = req & live_mask();

  for (genvar g = 0; g < int'(FLAT_W); g++) begin : g_slot
    assign bad[g]      = !blocked && live[g] && !sen[g];
    assign pend_set[g] = !blocked && live[g] &&  sen[g] && !ien[g];
    assign elig[g]     = !blocked && live[g] &&  sen[g] &&  ien[g];
  end

  assign fault_hit = |bad;
  assign disp_fire = |elig;
  assign disp_slot = lowest_slot(elig);
endmodule

// File: rtl/slot_irq_pending.sv
module slot_irq_pending
  import slot_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  flat_t pend_set,
  input  flat_t ien,
  input  logic  clr_valid,
  input  slot_t clr_slot,
  input  logic  blocked,
  output flat_t pend
);
  flat_t pend_clr;

  assign pend_clr = clr_valid ? slot_bit(clr_slot) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend | pend_set) & ~ien & ~pend_clr & live_mask();
  end

  AST_PEND_ONLY_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & $past(ien)) == '0)); // R4
  AST_ENABLE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(ien)) == '0)); // R5
  AST_CMD_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> ((pend & slot_bit($past(clr_slot))) == '0)); // R6
  AST_BUSY_NO_NEW_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> ((pend & ~$past(pend)) == '0)); // R8
endmodule

// File: rtl/slot_irq_ctx.sv
module slot_irq_ctx
  import slot_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  disp_fire,
  input  slot_t disp_slot,
  input  logic  isr_done,
  input  ctx_t  ctx_in,
  output logic  dispatch,
  output slot_t dispatch_slot,
  output logic  isr_active,
  output logic  restore_valid,
  output ctx_t  restore
);
  ctx_t saved;
  logic finish;

  assign finish = isr_done && isr_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saved         <= '0;
      restore       <= '0;
      dispatch      <= 1'b0;
      dispatch_slot <= '0;
      isr_active    <= 1'b0;
      restore_valid <= 1'b0;
    end else begin
      dispatch      <= disp_fire;
      restore_valid <= finish;
      if (disp_fire) begin
        saved         <= ctx_in;
        dispatch_slot <= disp_slot;
        isr_active    <= 1'b1;
      end else if (finish) begin
        isr_active <= 1'b0;
        restore    <= saved;
      end
    end
  end

  AST_SINGLE_ROUTINE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |-> !isr_active); // R7
  AST_RESTORE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> ($past(isr_done) && $past(isr_active) && !isr_active)); // R9
  AST_DISPATCH_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> isr_active); // R7
endmodule

// File: rtl/slot_irq_ctrl.sv
module slot_irq_ctrl
  import slot_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [NUM_SLOTS:1]  slot_req,
  input  logic                end_of_scan,
  input  logic                clr_pend_valid,
  input  logic [SLOT_W-1:0]   clr_pend_slot,
  input  logic                hp_busy,
  input  logic                isr_done,
  input  logic [WORD_W-1:0]   ctx_flags_in,
  input  logic [WORD_W-1:0]   ctx_math_lo_in,
  input  logic [WORD_W-1:0]   ctx_math_hi_in,
  input  logic [WORD_W-1:0]   ctx_index_in,
  output logic                dispatch,
  output logic [SLOT_W-1:0]   dispatch_slot,
  output logic                isr_active,
  output logic                major_fault,
  output logic                restore_valid,
  output logic [WORD_W-1:0]   restore_flags,
  output logic [WORD_W-1:0]   restore_math_lo,
  output logic [WORD_W-1:0]   restore_math_hi,
  output logic [WORD_W-1:0]   restore_index
);
  flat_t req_flat, sen_act, ien_act, pend, pend_set, elig;
  logic  blocked, fault_hit, disp_fire;
  slot_t disp_slot;
  ctx_t  ctx_now, ctx_back;

  assign req_flat = req_to_flat(slot_req);
  assign blocked  = isr_active || hp_busy;
  assign ctx_now  = '{flags: ctx_flags_in, math_lo: ctx_math_lo_in,
                      math_hi: ctx_math_hi_in, index: ctx_index_in};

  slot_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .eos(end_of_scan), .pend(pend), .rdata(reg_rdata),
    .sen_act(sen_act), .ien_act(ien_act)
  );

  slot_irq_screen u_screen (
    .req(req_flat), .sen(sen_act), .ien(ien_act), .blocked(blocked),
    .fault_hit(fault_hit), .pend_set(pend_set), .elig(elig),
    .disp_fire(disp_fire), .disp_slot(disp_slot)
  );

  slot_irq_pending u_pending (
    .clk(clk), .rst_n(rst_n), .pend_set(pend_set), .ien(ien_act),
    .clr_valid(clr_pend_valid), .clr_slot(clr_pend_slot),
    .blocked(blocked), .pend(pend)
  );

  slot_irq_ctx u_ctx (
    .clk(clk), .rst_n(rst_n), .disp_fire(disp_fire), .disp_slot(disp_slot),
    .isr_done(isr_done), .ctx_in(ctx_now), .dispatch(dispatch),
    .dispatch_slot(dispatch_slot), .isr_active(isr_active),
    .restore_valid(restore_valid), .restore(ctx_back)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         major_fault <= 1'b0;
    else if (fault_hit) major_fault <= 1'b1;
  end

  assign restore_flags   = ctx_back.flags;
  assign restore_math_lo = ctx_back.math_lo;
  assign restore_math_hi = ctx_back.math_hi;
  assign restore_index   = ctx_back.index;

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    major_fault |=> major_fault); // R3
  AST_DISPATCH_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> (($past(elig) & (slot_bit(dispatch_slot) - flat_t'(1))) == '0
                  && ($past(elig) & slot_bit(dispatch_slot)) != '0)); // R7
  AST_BUSY_NO_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hp_busy |=> !dispatch); // R8
endmodule

// File: tb/slot_irq_ctrl_bench.sv
module slot_irq_ctrl_bench;
  localparam int N = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [N:1]  slot_req = '0;
  logic        end_of_scan = 1'b0;
  logic        clr_pend_valid = 1'b0;
  logic [4:0]  clr_pend_slot = '0;
  logic        hp_busy = 1'b0;
  logic        isr_done = 1'b0;
  logic [15:0] cf = '0, cml = '0, cmh = '0, cix = '0;
  logic        dispatch, isr_active, major_fault, restore_valid;
  logic [4:0]  dispatch_slot;
  logic [15:0] rf, rml, rmh, rix;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  logic [31:0] m_sen_sh, m_ien_sh, m_sen, m_ien, m_pend;
  logic        m_fault, m_act, m_disp, m_rv;
  logic [4:0]  m_dslot;
  logic [63:0] m_saved, m_rst;

  always #10 clk = ~clk;

  slot_irq_ctrl u_slot_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slot_req(slot_req),
    .end_of_scan(end_of_scan), .clr_pend_valid(clr_pend_valid),
    .clr_pend_slot(clr_pend_slot), .hp_busy(hp_busy), .isr_done(isr_done),
    .ctx_flags_in(cf), .ctx_math_lo_in(cml), .ctx_math_hi_in(cmh),
    .ctx_index_in(cix), .dispatch(dispatch), .dispatch_slot(dispatch_slot),
    .isr_active(isr_active), .major_fault(major_fault),
    .restore_valid(restore_valid), .restore_flags(rf),
    .restore_math_lo(rml), .restore_math_hi(rmh), .restore_index(rix)
  );

  function automatic int b_lowest(logic [31:0] v);
    for (int i = 1; i <= N; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [15:0] b_read(logic [2:0] a);
    logic [31:0] src;
    case (a[2:1])
      2'd0: src = m_sen;
      2'd1: src = m_ien;
      2'd2: src = m_pend;
      default: src = '0;
    endcase
    return a[0] ? src[31:16] : src[15:0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sen_sh = '0; m_ien_sh = '0; m_sen = '0; m_ien = '0; m_pend = '0;
    m_fault = 0; m_act = 0; m_disp = 0; m_rv = 0; m_dslot = '0;
    m_saved = '0; m_rst = '0;
  endtask

  task automatic model_step();
    logic [31:0] rq, clr, set, elig, wmask;
    logic blk;
    rq  = {1'b0, slot_req, 1'b0};
    blk = m_act || hp_busy;
    set = '0; elig = '0;
    if (!blk) begin
      if ((rq & ~m_sen) != 0) m_fault = 1;
      set  = rq & m_sen & ~m_ien;
      elig = rq & m_sen & m_ien;
    end
    clr = '0;
    if (clr_pend_valid && clr_pend_slot >= 1 && clr_pend_slot <= N) clr[clr_pend_slot] = 1'b1;
    m_pend = (m_pend | set) & ~m_ien & ~clr;
    m_rv = 0;
    m_disp = 0;
    if (elig != 0) begin
      m_disp = 1; m_dslot = 5'(b_lowest(elig)); m_act = 1;
      m_saved = {cf, cml, cmh, cix};
    end else if (m_act && isr_done) begin
      m_rv = 1; m_act = 0; m_rst = m_saved;
    end
    if (reg_wr && reg_addr[2:1] == 2'd0)
      m_sen_sh = (reg_addr[0] ? {reg_wdata, m_sen_sh[15:0]} : {m_sen_sh[31:16], reg_wdata}) & 32'h7FFF_FFFE;
    if (reg_wr && reg_addr[2:1] == 2'd1)
      m_ien_sh = (reg_addr[0] ? {reg_wdata, m_ien_sh[15:0]} : {m_ien_sh[31:16], reg_wdata}) & 32'h7FFF_FFFE;
    if (end_of_scan) begin m_sen = m_sen_sh; m_ien = m_ien_sh; end
    wmask = '0;
  endtask

  task automatic compare();
    chk("R7 dispatch pulse", dispatch, m_disp);
    if (m_disp) chk("R7 dispatch slot", dispatch_slot, m_dslot);
    chk("R3 major_fault", major_fault, m_fault);
    chk("R9 isr_active", isr_active, m_act);
    chk("R9 restore_valid", restore_valid, m_rv);
    if (m_rv) chk("R9 restored words", {rf, rml, rmh, rix}, m_rst);
    chk("R1 R2 register read", reg_rdata, b_read(reg_addr));
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 0; slot_req = '0; reg_wr = 0; end_of_scan = 0;
    clr_pend_valid = 0; hp_busy = 0; isr_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    do_reset();
    // R11 reset state
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a); #1;
      chk("R11 reset register read", reg_rdata, 16'h0);
    end
    chk("R11 reset outputs", {dispatch, isr_active, major_fault, restore_valid}, 4'b0);
    reg_addr = 3'd0;

    // R2 staging, R1 reserved bits
    reg_wr = 1; reg_wdata = 16'hFFFF; cycle();
    reg_wr = 0; cycle();
    chk("R2 write not yet live", reg_rdata, 16'h0);
    end_of_scan = 1; cycle(); end_of_scan = 0;
    chk("R1 low word bit0 reads zero", reg_rdata, 16'hFFFE);
    reg_addr = 3'd1; reg_wr = 1; end_of_scan = 1; cycle();
    reg_wr = 0; end_of_scan = 0;
    chk("R2 same-cycle write taken at scan end", reg_rdata, 16'h7FFF);
    reg_addr = 3'd2; reg_wr = 1; cycle();
    reg_addr = 3'd3; cycle();
    reg_wr = 0; end_of_scan = 1; cycle(); end_of_scan = 0;

    // R7 priority, R9 context, R10 held request
    cf = 16'h1111; cml = 16'h2222; cmh = 16'h3333; cix = 16'h4444;
    slot_req[5] = 1; slot_req[9] = 1; cycle();
    chk("R7 lowest slot first", {dispatch, dispatch_slot}, {1'b1, 5'd5});
    cf = 16'hAAAA; cycle();
    chk("R8 no dispatch while in service", dispatch, 1'b0);
    isr_done = 1; cycle(); isr_done = 0;
    chk("R9 saved context returned", {restore_valid, rf, rml, rmh, rix},
        {1'b1, 64'h1111_2222_3333_4444});
    cycle();
    chk("R10 held request dispatched again", {dispatch, dispatch_slot}, {1'b1, 5'd5});
    slot_req = '0; isr_done = 1; cycle(); isr_done = 0; cycle();

    // R4 pending set
    reg_addr = 3'd2; reg_wr = 1; reg_wdata = 16'hFFF7; end_of_scan = 1; cycle();
    reg_wr = 0; end_of_scan = 0;
    slot_req[3] = 1; cycle(); slot_req = '0;
    reg_addr = 3'd4; cycle();
    chk("R4 masked slot becomes pending", reg_rdata, 16'h0008);

    // R6 clear command
    clr_pend_valid = 1; clr_pend_slot = 5'd0; cycle();
    clr_pend_slot = 5'd31; cycle(); clr_pend_valid = 0;
    chk("R6 out-of-range slot ignored", reg_rdata, 16'h0008);
    clr_pend_valid = 1; clr_pend_slot = 5'd3; slot_req[3] = 1; cycle();
    clr_pend_valid = 0; slot_req = '0;
    chk("R6 clear wins over set", reg_rdata, 16'h0000);

    // R8 busy blocks pending, R10 evaluated after release
    hp_busy = 1; slot_req[3] = 1; cycle(); cycle();
    chk("R8 no pending while busy", reg_rdata, 16'h0000);
    hp_busy = 0; cycle();
    chk("R10 held request evaluated after busy", reg_rdata, 16'h0008);
    slot_req = '0;

    // R5 clear by enable, only after scan end
    reg_addr = 3'd2; reg_wr = 1; reg_wdata = 16'hFFFF; cycle();
    reg_wr = 0; reg_addr = 3'd4; cycle();
    chk("R5 still pending before scan end", reg_rdata, 16'h0008);
    end_of_scan = 1; cycle(); end_of_scan = 0; cycle();
    chk("R5 enable clears pending", reg_rdata, 16'h0000);

    // random phase: slot enables stay full, all else random
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom & $urandom & $urandom;
      slot_req = r[N:1];
      reg_addr = 3'($urandom_range(2, 7));
      reg_wr = ($urandom % 3) == 0;
      reg_wdata = 16'($urandom);
      end_of_scan = ($urandom % 10) == 0;
      clr_pend_valid = ($urandom % 4) == 0;
      clr_pend_slot = 5'($urandom);
      hp_busy = ($urandom % 5) == 0;
      isr_done = ($urandom % 3) == 0;
      cf = 16'($urandom); cml = 16'($urandom);
      cmh = 16'($urandom); cix = 16'($urandom);
      cycle();
    end

    // R3 fault, deferred while busy (R8)
    do_reset();
    reg_addr = 3'd0; hp_busy = 1; slot_req[2] = 1; cycle();
    chk("R8 no fault while busy", major_fault, 1'b0);
    hp_busy = 0; cycle();
    chk("R3 disabled slot raises fault", major_fault, 1'b1);
    slot_req = '0; cycle(); cycle();
    chk("R3 fault stays latched", major_fault, 1'b1);
    chk("R3 no dispatch for disabled slot", dispatch, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule